// File: doc/BRIEF.md
# Regulator Soft-Start Sequencer

This block brings a voltage regulator's reference up in a controlled way. It watches three already-digitised qualification flags: bias supply good, main enable and auxiliary enable. Once all three are true it runs a fixed settling delay. It then ramps an unsigned DAC code from zero to a boot plateau and parks there.

While parked, the block waits for the 8-bit voltage-select (VID) input to settle. It then samples that input and does one of two things. A normal code starts a second ramp, up or down, to the requested level less a programmed offset. The reserved off pattern instead shuts the regulator down and keeps it down. One DAC code step is 6.25 mV throughout.

The outputs drive a DAC, the enable of the PWM output buffers (low means the buffers float so the external drivers stay off), and a ready flag for the rest of the system. All inputs and outputs are plain level signals. Nothing streams through the block, so it has no handshake and no back-pressure.

Top module: `vr_softstart_seq`

## Requirements
- R1: After reset, and in every cycle of shutdown, `dac_code` is 0, `pwm_oe` is 0 and `vr_ready` is 0.
- R2: The sequence leaves shutdown only at a clock edge that sees `bias_ok`, `en_main` and `en_aux` all high. At the first edge that sees any of them low, `dac_code`, `pwm_oe` and `vr_ready` all become 0.
- R3: `pwm_oe` rises exactly DLY_CYC edges after the edge that started the sequence. `dac_code` stays 0 until then.
- R4: During the boot ramp, `dac_code` rises by exactly 1 (6.25 mV) every STEP_CYC cycles. The first step comes STEP_CYC edges after `pwm_oe` rises. The code stops at BOOT_CODE and never passes it.
- R5: The code rests at BOOT_CODE for at least HOLD_CYC cycles. The rest lasts until the plateau has run that long and `vid_in` has kept one value for VID_STABLE_CYC consecutive edges. The settled value is the one sampled.
- R6: The target is VID_BASE + VID_GAIN·vid − VID_OFFSET, clamped to the DAC range. The final ramp starts at the sampling edge. It moves the code by 1 toward the target every STEP_CYC cycles, up or down, and stops exactly on the target.
- R7: `vr_ready` rises one edge after `dac_code` equals the target. If the target equals BOOT_CODE, it rises at the sampling edge. It is never high before that.
- R8: If the sampled value equals OFF_VID (default 8'hFF), `pwm_oe` falls at the sampling edge and `dac_code` reads 0 one edge later. The block then stays off while all flags remain high. Dropping a flag and raising all three again restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply above its power-on threshold |
| en_main | input | 1 | Main enable, already compared against its threshold |
| en_aux | input | 1 | Auxiliary enable, already compared against its threshold |
| vid_in | input | VID_W | Requested voltage code |
| dac_code | output | DAC_W | Reference code in 6.25 mV units |
| pwm_oe | output | 1 | PWM output enable; low floats the PWM pins |
| vr_ready | output | 1 | Output has reached its operating level |

## Verification
The start-up sequence is run with three kinds of VID request. A target above the boot plateau checks upward stepping. A target below it checks downward stepping. A target equal to it checks that ready rises with no second ramp. A VID change late in the plateau separates the minimum hold time from the stability wait. Flag drops during the boot ramp, while running and while latched off show whether shutdown is immediate and whether the off latch clears only through a flag cycle. A queue of expected DAC, enable and ready transitions, each stamped with its clock edge, is compared against every transition the block makes. Any extra, missing or late step is therefore seen.

// File: rtl/vrss_pkg.sv
package vrss_pkg;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_DELAY,
    PH_BOOT_RAMP,
    PH_BOOT_HOLD,
    PH_FINAL_RAMP,
    PH_RUN,
    PH_LATCHED
  } vrss_phase_e;

endpackage

// File: rtl/vrss_vid_qual.sv
module vrss_vid_qual #(
  parameter int VID_W          = 8,
  parameter int DAC_W          = 10,
  parameter int VID_STABLE_CYC = 50,
  parameter int VID_BASE       = 80,
  parameter int VID_GAIN       = 2,
  parameter int VID_OFFSET     = 0,
  parameter logic [VID_W-1:0] OFF_VID = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] vid_in,
  output logic             vid_settled,
  output logic             vid_is_off,
  output logic [DAC_W-1:0] vid_target
);

  localparam int SC_W    = $clog2(VID_STABLE_CYC + 1);
  localparam int DAC_MAX = (1 << DAC_W) - 1;
  localparam logic [SC_W-1:0] SC_LIM = SC_W'(VID_STABLE_CYC);

  logic [VID_W-1:0] vid_q;
  logic [SC_W-1:0]  same_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q    <= '0;
      same_cnt <= '0;
    end else begin
      vid_q <= vid_in;
      if (vid_in != vid_q)
        same_cnt <= '0;
      else if (same_cnt != SC_LIM)
        same_cnt <= same_cnt + 1'b1;
    end
  end

  assign vid_settled = (same_cnt == SC_LIM);
  assign vid_is_off  = (vid_q == OFF_VID);

  always_comb begin
    int raw;
    raw = VID_BASE + VID_GAIN * int'(vid_q) - VID_OFFSET;
    if (raw < 0)
      vid_target = '0;
    else if (raw > DAC_MAX)
      vid_target = '1;
    else
      vid_target = DAC_W'(raw);
  end

  // R5
  settled_value_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_settled |-> (vid_q == $past(vid_q)));

endmodule

// File: rtl/vrss_dac_ramp.sv
module vrss_dac_ramp #(
  parameter int DAC_W    = 10,
  parameter int STEP_CYC = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [DAC_W-1:0] goal,
  output logic [DAC_W-1:0] dac_q,
  output logic             at_goal
);

  localparam int TC_W = $clog2(STEP_CYC + 1);
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(STEP_CYC - 1);

  logic [TC_W-1:0] tick_cnt;

  assign at_goal = (dac_q == goal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q    <= '0;
      tick_cnt <= '0;
    end else if (clr) begin
      dac_q    <= '0;
      tick_cnt <= '0;
    end else if (run && !at_goal) begin
      if (tick_cnt == TC_LAST) begin
        tick_cnt <= '0;
        if (dac_q < goal)
          dac_q <= dac_q + 1'b1;
        else
          dac_q <= dac_q - 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end else begin
      tick_cnt <= '0;
    end
  end

  // R4
  single_lsb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (dac_q == $past(dac_q) || dac_q == $past(dac_q) + 1'b1 ||
              dac_q + 1'b1 == $past(dac_q)));

  // R6
  park_on_goal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_goal && !clr) |=> $stable(dac_q));

endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
  import vrss_pkg::*;
#(
  parameter int VID_W          = 8,
  parameter int DAC_W          = 10,
  parameter int DLY_CYC        = 136000,
  parameter int STEP_CYC       = 100,
  parameter int BOOT_CODE      = 176,
  parameter int HOLD_CYC       = 8500,
  parameter int VID_STABLE_CYC = 50,
  parameter int VID_BASE       = 80,
  parameter int VID_GAIN       = 2,
  parameter int VID_OFFSET     = 0,
  parameter logic [VID_W-1:0] OFF_VID = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bias_ok,
  input  logic             en_main,
  input  logic             en_aux,
  input  logic [VID_W-1:0] vid_in,
  output logic [DAC_W-1:0] dac_code,
  output logic             pwm_oe,
  output logic             vr_ready
);

  localparam int TMR_MAX = (DLY_CYC > HOLD_CYC) ? DLY_CYC : HOLD_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] DLY_LAST  = TMR_W'(DLY_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(HOLD_CYC - 1);
  localparam logic [DAC_W-1:0] BOOT_L    = DAC_W'(BOOT_CODE);

  vrss_phase_e     st, nxt;
  logic [TMR_W-1:0] tmr;
  logic [DAC_W-1:0] tgt_q;
  logic             en_all;
  logic             vid_settled, vid_is_off;
  logic [DAC_W-1:0] vid_target;
  logic             ramp_clr, ramp_run, ramp_at_goal;
  logic [DAC_W-1:0] ramp_goal;
  logic             dly_done, hold_done;

  assign en_all    = bias_ok && en_main && en_aux;
  assign dly_done  = (tmr == DLY_LAST);
  assign hold_done = (tmr == HOLD_LAST);

  vrss_vid_qual #(
    .VID_W(VID_W), .DAC_W(DAC_W), .VID_STABLE_CYC(VID_STABLE_CYC),
    .VID_BASE(VID_BASE), .VID_GAIN(VID_GAIN), .VID_OFFSET(VID_OFFSET),
    .OFF_VID(OFF_VID)
  ) u_vid (
    .clk(clk), .rst_n(rst_n), .vid_in(vid_in),
    .vid_settled(vid_settled), .vid_is_off(vid_is_off), .vid_target(vid_target)
  );

  always_comb begin
    nxt = st;
    if (!en_all) begin
      nxt = PH_OFF;
    end else begin
      unique case (st)
        PH_OFF:        nxt = PH_DELAY;
        PH_DELAY:      if (dly_done) nxt = PH_BOOT_RAMP;
        PH_BOOT_RAMP:  if (ramp_at_goal) nxt = PH_BOOT_HOLD;
        PH_BOOT_HOLD:
          if (hold_done && vid_settled) begin
            if (vid_is_off)                nxt = PH_LATCHED;
            else if (vid_target == dac_code) nxt = PH_RUN;
            else                           nxt = PH_FINAL_RAMP;
          end
        PH_FINAL_RAMP: if (ramp_at_goal) nxt = PH_RUN;
        PH_RUN:        nxt = PH_RUN;
        PH_LATCHED:    nxt = PH_LATCHED;
        default:       nxt = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PH_OFF;
      tmr   <= '0;
      tgt_q <= '0;
    end else begin
      st <= nxt;
      if (nxt != st)
        tmr <= '0;
      else if (st == PH_DELAY && !dly_done)
        tmr <= tmr + 1'b1;
      else if (st == PH_BOOT_HOLD && !hold_done)
        tmr <= tmr + 1'b1;
      if (st == PH_BOOT_HOLD && (nxt == PH_FINAL_RAMP || nxt == PH_RUN))
        tgt_q <= vid_target;
    end
  end

  assign ramp_clr  = !en_all || st == PH_OFF || st == PH_DELAY || st == PH_LATCHED;
  assign ramp_run  = (st == PH_BOOT_RAMP) || (st == PH_FINAL_RAMP);
  assign ramp_goal = (st == PH_FINAL_RAMP || st == PH_RUN) ? tgt_q : BOOT_L;

  vrss_dac_ramp #(.DAC_W(DAC_W), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .run(ramp_run),
    .goal(ramp_goal), .dac_q(dac_code), .at_goal(ramp_at_goal)
  );

  assign pwm_oe   = (st == PH_BOOT_RAMP) || (st == PH_BOOT_HOLD) ||
                    (st == PH_FINAL_RAMP) || (st == PH_RUN);
  assign vr_ready = (st == PH_RUN);

  // R2
  drop_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_all |=> (!pwm_oe && !vr_ready && dac_code == '0));

  // R3
  delay_dac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_DELAY) |-> (dac_code == '0 && !pwm_oe));

  // R7
  ready_on_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vr_ready |-> (dac_code == tgt_q));

  // R8
  latch_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_LATCHED && en_all) |=> (st == PH_LATCHED && !pwm_oe));

  // R4
  boot_no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_BOOT_RAMP) |-> (dac_code <= BOOT_L));

endmodule

// File: tb/vr_softstart_seq_test.sv
module vr_softstart_seq_test;

  localparam int DLY = 40, STEP = 4, BOOT = 176, HOLD = 20, STAB = 5;
  localparam int BASE = 80, GAIN = 2, OFS = 2, DW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bias_ok = 1'b0, en_main = 1'b0, en_aux = 1'b0;
  logic [7:0] vid_in = 8'd60;
  logic [DW-1:0] dac_code;
  logic pwm_oe, vr_ready;

  always #5 clk = ~clk;

  vr_softstart_seq #(
    .VID_W(8), .DAC_W(DW), .DLY_CYC(DLY), .STEP_CYC(STEP), .BOOT_CODE(BOOT),
    .HOLD_CYC(HOLD), .VID_STABLE_CYC(STAB), .VID_BASE(BASE), .VID_GAIN(GAIN),
    .VID_OFFSET(OFS), .OFF_VID(8'hFF)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .en_main(en_main),
    .en_aux(en_aux), .vid_in(vid_in), .dac_code(dac_code),
    .pwm_oe(pwm_oe), .vr_ready(vr_ready)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int sig; int edge_n; int val; string req; } ev_t;
  ev_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [DW-1:0] p_dac = '0;
  logic p_oe = 1'b0, p_rdy = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void push(input int s, input int e, input int v, input string r);
    ev_t ev;
    ev.sig = s; ev.edge_n = e; ev.val = v; ev.req = r;
    exp_q.push_back(ev);
  endfunction

  // monitor: every observed transition is popped against the expected queue
  task automatic take(input int s, input int v);
    ev_t ev;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R2", $sformatf("unexpected change sig%0d at edge %0d", s, cyc), v, -1);
    end else begin
      ev = exp_q.pop_front();
      chk(ev.sig == s && ev.edge_n == cyc && ev.val == v, ev.req,
          $sformatf("sig%0d/edge%0d vs sig%0d/edge%0d", s, cyc, ev.sig, ev.edge_n),
          v, ev.val);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (dac_code != p_dac) begin take(0, int'(dac_code)); p_dac = dac_code; end
      if (pwm_oe != p_oe)    begin take(1, int'(pwm_oe));   p_oe = pwm_oe;     end
      if (vr_ready != p_rdy) begin take(2, int'(vr_ready)); p_rdy = vr_ready;  end
    end
  end

  task automatic wait_to(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  function automatic int tgt_of(input int v);
    return BASE + GAIN * v - OFS;
  endfunction

  function automatic int hold_edge(input int ts);
    return ts + DLY + BOOT * STEP + 1;
  endfunction

  task automatic launch(output int ts);
    ts = cyc + 1;
    bias_ok = 1'b1; en_main = 1'b1; en_aux = 1'b1;
  endtask

  // driver: expected delay and boot ramp up to a given code
  task automatic push_boot(input int ts, input int upto);
    int e0;
    e0 = ts + DLY;
    push(1, e0, 1, "R3");
    for (int v = 1; v <= upto; v++) push(0, e0 + v * STEP, v, "R4");
  endtask

  // driver: expected final ramp; returns edge where ready rises
  task automatic push_final(input int x, input int tg, output int rdy_e);
    int n;
    if (tg == BOOT) begin
      push(2, x, 1, "R7");
      rdy_e = x;
    end else begin
      n = (tg > BOOT) ? tg - BOOT : BOOT - tg;
      for (int k = 1; k <= n; k++)
        push(0, x + k * STEP, (tg > BOOT) ? BOOT + k : BOOT - k, "R6");
      rdy_e = x + n * STEP + 1;
      push(2, rdy_e, 1, "R7");
    end
  endtask

  task automatic run_normal(input int v);
    int ts, x, re;
    launch(ts);
    push_boot(ts, BOOT);
    x = hold_edge(ts) + HOLD;
    push_final(x, tgt_of(v), re);
    wait_to(re + 3);
    chk(vr_ready == 1'b1, "R7", "ready after final ramp", int'(vr_ready), 1);
    chk(int'(dac_code) == tgt_of(v), "R6", "final dac code", int'(dac_code), tgt_of(v));
  endtask

  task automatic drop_main();
    int d;
    d = cyc + 1;
    en_main = 1'b0;
    if (dac_code != '0) push(0, d, 0, "R2");
    if (pwm_oe) push(1, d, 0, "R2");
    if (vr_ready) push(2, d, 0, "R2");
    wait_to(d + 3);
    chk(dac_code == '0 && !pwm_oe && !vr_ready, "R1", "outputs idle in shutdown",
        int'(dac_code) + int'(pwm_oe) + int'(vr_ready), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual cycle %0d expected finish before %0d", cyc, 200000);
      summary();
      $finish;
    end
  end

  initial begin
    int ts, h, x, re, e0, d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dac_code == '0, "R1", "dac after reset", int'(dac_code), 0);
    chk(!pwm_oe, "R1", "pwm_oe after reset", int'(pwm_oe), 0);
    chk(!vr_ready, "R1", "ready after reset", int'(vr_ready), 0);

    // R2: two of three flags are not enough
    bias_ok = 1'b1; en_main = 1'b1;
    wait_to(cyc + 60);
    chk(!pwm_oe && dac_code == '0, "R2", "partial enable stays off",
        int'(pwm_oe) + int'(dac_code), 0);

    // target above boot
    run_normal(60);
    drop_main();

    // target below boot
    vid_in = 8'd40;
    wait_to(cyc + 10);
    run_normal(40);
    drop_main();

    // target equal to boot
    vid_in = 8'd49;
    wait_to(cyc + 10);
    run_normal(49);
    drop_main();

    // R5: late VID change stretches the plateau
    vid_in = 8'd60;
    wait_to(cyc + 10);
    launch(ts);
    push_boot(ts, BOOT);
    h = hold_edge(ts);
    wait_to(h + 17);
    vid_in = 8'd61;
    x = h + 18 + STAB + 1;
    push_final(x, tgt_of(61), re);
    wait_to(x - 1);
    chk(int'(dac_code) == BOOT && !vr_ready, "R5", "still parked at boot", int'(dac_code), BOOT);
    wait_to(re + 3);
    chk(int'(dac_code) == tgt_of(61), "R5", "settled value used", int'(dac_code), tgt_of(61));
    drop_main();

    // R2: flag drop in the middle of the boot ramp
    vid_in = 8'd60;
    wait_to(cyc + 10);
    launch(ts);
    e0 = ts + DLY;
    push_boot(ts, 10);
    wait_to(e0 + 10 * STEP + 1);
    d = cyc + 1;
    bias_ok = 1'b0;
    push(0, d, 0, "R2");
    push(1, d, 0, "R2");
    wait_to(d + 3);
    chk(dac_code == '0 && !pwm_oe, "R2", "mid-ramp drop clears", int'(dac_code), 0);
    en_main = 1'b0;
    bias_ok = 1'b1;
    wait_to(cyc + 5);

    // R8: off code latches, flag cycle restarts
    vid_in = 8'hFF;
    wait_to(cyc + 10);
    launch(ts);
    push_boot(ts, BOOT);
    x = hold_edge(ts) + HOLD;
    push(1, x, 0, "R8");
    push(0, x + 1, 0, "R8");
    wait_to(x + 30);
    chk(!pwm_oe && dac_code == '0 && !vr_ready, "R8", "latched off with flags high",
        int'(pwm_oe) + int'(dac_code), 0);
    en_aux = 1'b0;
    vid_in = 8'd60;
    wait_to(cyc + 12);
    chk(!pwm_oe && dac_code == '0, "R8", "still off while flag low", int'(pwm_oe), 0);
    run_normal(60);
    drop_main();

    wait_to(cyc + 5);
    chk(exp_q.size() == 0, "R7", "expected transitions left", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule